// File: doc/BRIEF.md
# Oscillator Sub-Band Calibration Controller

This controller picks one of sixteen discrete sub-bands of a multi-band LC oscillator inside a frequency synthesizer before the loop is closed. On a start strobe it captures the programmed division ratio, asserts a clamp that holds the analog tuning voltage at mid-range, and then visits every band in turn. For each band it waits a programmable settling time. It then counts the pulses of a prescaled oscillator signal over a fixed window of reference cycles.

Each count is compared with the count that the division ratio calls for, and the band with the smallest absolute difference is kept. Band code 0 is the highest-frequency band, and frequency falls as the code rises. After the sixteenth band the controller drives the winning code and releases the clamp, so the loop locks near the centre of that band's tuning curve. It also pulses a done flag for one cycle. The whole design runs on the reference clock. The pulse input is expected to be already synchronous: it is high for one cycle per prescaler output edge.

Top module: `abs_band_cal`

## Requirements
- R1: After a synchronous reset, `band_code` is 0, `vt_clamp` is 0 and `cal_done` is 0.
- R2: A `start` sampled high while idle begins a calibration. `vt_clamp` is 1 throughout. `band_code` steps 0, 1, …, 15 in ascending order, and each band is held for `settle_len + 1 + WIN` cycles, counted from the edge that sampled `start`.
- R3: For each band, `fb_pulse` is counted only during the last `WIN` cycles of that band's slot. Pulses during the `settle_len + 1` settling cycles are ignored.
- R4: The target count is `N * WIN / PRESC`, where N is the division ratio captured at start. The band error is the absolute difference between the count and the target. The band with the smallest error is selected.
- R5: When two bands have equal error, the lower band code is selected.
- R6: `cal_done` is high for exactly one cycle, at the edge `16 * (settle_len + 1 + WIN)` cycles after the edge that sampled `start`. In that same cycle `band_code` shows the selected band and `vt_clamp` is 0.
- R7: While idle and with no `start`, `band_code` holds its value, including after a long wait and with a changed `div_ratio`.
- R8: A `start` pulse during a running calibration has no effect. The band sequence, the done timing and the result are unchanged.
- R9: `div_ratio` is captured only when a calibration begins. Changing it during a calibration does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin calibration (honoured only when idle) |
| div_ratio | input | N_W | Programmed division ratio N |
| settle_len | input | SET_W | Settling cycles after each band switch, minus one |
| fb_pulse | input | 1 | One-cycle pulse per prescaled oscillator edge |
| band_code | output | 4 | Oscillator sub-band select, 0 = highest frequency |
| vt_clamp | output | 1 | Hold tuning voltage at mid-range |
| cal_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with PRESC = 64 and WIN = 128, so the target is exactly twice N. The oscillator model gives band b a fixed number of pulses in every 64 cycles. Any 128-cycle window therefore holds an exact, phase-independent count, and every band error is known in advance. This makes exact ties between neighbouring bands reachable, along with the extremes where the winner is band 0 or band 15. A long settling time of 100 cycles makes any leak of settling pulses into the count visible. A settling value of 0 exercises the shortest slot.

// File: rtl/abs_pkg.sv
package abs_pkg;

    localparam int CNT_W     = 16;
    localparam int BAND_W    = 4;
    localparam int NUM_BANDS = 1 << BAND_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BAND_W-1:0] band_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_COUNT  = 2'd2
    } phase_e;

    localparam band_t LAST_BAND = band_t'(NUM_BANDS - 1);

    function automatic cnt_t abs_diff(input cnt_t a, input cnt_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/abs_meas.sv
module abs_meas
    import abs_pkg::*;
#(
    parameter int WIN   = 1024,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [SET_W-1:0] settle_len,
    input  logic             fb_pulse,
    output logic             last,
    output cnt_t             count
);
    localparam int WIN_W = $clog2(WIN) + 1;
    localparam int TW    = (SET_W > WIN_W) ? SET_W : WIN_W;

    phase_e        phase;
    logic [TW-1:0] tcnt;
    cnt_t          ecnt;

    assign last  = (phase == PH_COUNT) && (tcnt == TW'(WIN - 1));
    assign count = ecnt + cnt_t'(fb_pulse);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tcnt  <= '0;
            ecnt  <= '0;
        end else if (go) begin
            phase <= PH_SETTLE;
            tcnt  <= '0;
            ecnt  <= '0;
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (tcnt == TW'(settle_len)) begin
                        phase <= PH_COUNT;
                        tcnt  <= '0;
                        ecnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                PH_COUNT: begin
                    ecnt <= count;
                    if (last) phase <= PH_IDLE;
                    else      tcnt  <= tcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3: at most one pulse counted per window cycle
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT) |-> (ecnt <= cnt_t'(tcnt)));

    // R3: the settling phase never adds to the count
    a_r3_settle_no_count: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETTLE) && !go && (tcnt != TW'(settle_len)) |=> (ecnt == '0));

endmodule

// File: rtl/abs_best.sv
module abs_best
    import abs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  logic  upd,
    input  band_t cand_band,
    input  cnt_t  cand_err,
    output band_t sel_band
);
    cnt_t  best_err;
    band_t best_band;
    logic  better;

    // strict compare: an equal error keeps the earlier, lower band
    assign better   = cand_err < best_err;
    assign sel_band = (upd && better) ? cand_band : best_band;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            best_err  <= '1;
            best_band <= '0;
        end else if (upd && better) begin
            best_err  <= cand_err;
            best_band <= cand_band;
        end
    end

    // R4: the kept error never grows within a calibration
    a_r4_best_monotone: assert property (@(posedge clk) disable iff (rst)
        !init |=> (best_err <= $past(best_err)));

    // R5: an equal error never displaces the kept band
    a_r5_tie_keeps: assert property (@(posedge clk) disable iff (rst)
        !init && upd && (cand_err == best_err) |=> $stable(best_band));

endmodule

// File: rtl/abs_band_cal.sv
module abs_band_cal
    import abs_pkg::*;
#(
    parameter int PRESC = 256,
    parameter int WIN   = 1024,
    parameter int N_W   = 8,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_W-1:0]   div_ratio,
    input  logic [SET_W-1:0] settle_len,
    input  logic             fb_pulse,
    output logic [3:0]       band_code,
    output logic             vt_clamp,
    output logic             cal_done
);
    // WIN must be a multiple of PRESC and below 2**CNT_W
    localparam int WPP = WIN / PRESC;

    logic           busy;
    band_t          band_r;
    logic [N_W-1:0] n_lat;
    logic           clamp_r;
    logic           done_r;

    logic  begin_cal;
    logic  meas_last;
    cnt_t  meas_cnt;
    cnt_t  target;
    cnt_t  err;
    band_t sel_band;
    logic  go;

    assign begin_cal = !busy && start;
    assign go        = begin_cal || (busy && meas_last && (band_r != LAST_BAND));
    assign target    = cnt_t'(n_lat) * cnt_t'(WPP);
    assign err       = abs_diff(meas_cnt, target);

    abs_meas #(.WIN(WIN), .SET_W(SET_W)) u_meas (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .settle_len (settle_len),
        .fb_pulse   (fb_pulse),
        .last       (meas_last),
        .count      (meas_cnt)
    );

    abs_best u_best (
        .clk       (clk),
        .rst       (rst),
        .init      (begin_cal),
        .upd       (busy && meas_last),
        .cand_band (band_r),
        .cand_err  (err),
        .sel_band  (sel_band)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            band_r  <= '0;
            n_lat   <= '0;
            clamp_r <= 1'b0;
            done_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (begin_cal) begin
                busy    <= 1'b1;
                band_r  <= '0;
                n_lat   <= div_ratio;
                clamp_r <= 1'b1;
            end else if (busy && meas_last) begin
                if (band_r == LAST_BAND) begin
                    busy    <= 1'b0;
                    clamp_r <= 1'b0;
                    done_r  <= 1'b1;
                    band_r  <= sel_band;
                end else begin
                    band_r <= band_r + 1'b1;
                end
            end
        end
    end

    assign band_code = band_r;
    assign vt_clamp  = clamp_r;
    assign cal_done  = done_r;

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (band_code == 4'd0) && !vt_clamp && !cal_done);

    // R2: clamp held for the whole calibration
    a_r2_clamp_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> vt_clamp);

    // R2: bands advance one step at a time
    a_r2_band_step: assert property (@(posedge clk) disable iff (rst)
        busy && meas_last && (band_r != LAST_BAND) |=> (band_code == $past(band_code) + 4'd1));

    // R6: done is a single-cycle pulse with the clamp released
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);
    a_r6_done_release: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> !vt_clamp && !busy);

    // R7: band code held while idle
    a_r7_band_hold: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(band_code));

    // R8, R9: captured ratio fixed during a run
    a_r9_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(n_lat));

endmodule

// File: tb/tb_abs_band_cal.sv
module tb_abs_band_cal;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC = 64;
    localparam int WIN   = 128;
    localparam int N_W   = 8;
    localparam int SET_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [N_W-1:0]   div_ratio = '0;
    logic [SET_W-1:0] settle_len = '0;
    logic             fb_pulse = 1'b0;
    logic [3:0]       band_code;
    logic             vt_clamp;
    logic             cal_done;

    int n_pass = 0;
    int n_total = 0;
    int step = 3;
    int ph = 0;

    abs_band_cal #(.PRESC(PRESC), .WIN(WIN), .N_W(N_W), .SET_W(SET_W)) dut (
        .clk(clk), .rst(rst), .start(start), .div_ratio(div_ratio),
        .settle_len(settle_len), .fb_pulse(fb_pulse),
        .band_code(band_code), .vt_clamp(vt_clamp), .cal_done(cal_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // oscillator model: band b gives 60 - step*b pulses in every 64 cycles
    always @(negedge clk) begin
        ph <= (ph == PRESC - 1) ? 0 : ph + 1;
        fb_pulse <= (ph < (60 - step * int'(band_code)));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    function automatic int expected_band(input int n, input int stp);
        int best = 0;
        int best_err = 1 << 30;
        for (int b = 0; b < 16; b++) begin
            int e = 2 * (60 - stp * b) - 2 * n;
            if (e < 0) e = -e;
            if (e < best_err) begin best_err = e; best = b; end
        end
        return best;
    endfunction

    task automatic t_reset();
        check(band_code == 4'd0, "R1 band after reset", band_code, 0);
        check(vt_clamp == 1'b0, "R1 clamp after reset", vt_clamp, 0);
        check(cal_done == 1'b0, "R1 done after reset", cal_done, 0);
    endtask

    // full calibration; inj_k > 0 pulses start with ratio inj_n at that cycle
    task automatic run_cal(input int n, input int stp, input int settle,
                           input int inj_k, input int inj_n, input string tag);
        int len = settle + 1 + WIN;
        int tot = 16 * len;
        int exp_b = expected_band(n, stp);
        bit seq_ok = 1'b1;
        int bad_act = 0;
        int bad_exp = 0;
        step = stp;
        settle_len = SET_W'(settle);
        div_ratio = N_W'(n);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 1; k <= tot + 1; k++) begin
            @(posedge clk); #1;
            if (k < tot) begin
                if (seq_ok && (int'(band_code) != k / len || !vt_clamp || cal_done)) begin
                    seq_ok = 1'b0;
                    bad_act = int'(band_code);
                    bad_exp = k / len;
                end
            end else if (k == tot) begin
                check(cal_done == 1'b1, {"R6 done at end ", tag}, cal_done, 1);
                check(vt_clamp == 1'b0, {"R6 clamp released ", tag}, vt_clamp, 0);
                check(int'(band_code) == exp_b, {"R4 R5 selected band ", tag}, band_code, exp_b);
            end else begin
                check(cal_done == 1'b0, {"R6 done single cycle ", tag}, cal_done, 0);
            end
            if (inj_k > 0 && k == inj_k) begin
                start = 1'b1;
                div_ratio = N_W'(inj_n);
            end
            if (inj_k > 0 && k == inj_k + 1) start = 1'b0;
        end
        check(seq_ok, {"R2 R3 band sweep and clamp ", tag}, bad_act, bad_exp);
    endtask

    task automatic t_hold();
        logic [3:0] held = band_code;
        div_ratio = N_W'(7);
        repeat (300) @(posedge clk);
        #1;
        check(band_code == held, "R7 band held while idle", band_code, held);
        check(vt_clamp == 1'b0, "R7 clamp stays released", vt_clamp, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        run_cal(45, 3, 5,   0, 0, "exact R4");
        run_cal(43, 3, 5,   0, 0, "nearest R4");
        run_cal(53, 2, 5,   0, 0, "tie R5");
        run_cal(63, 3, 0,   0, 0, "top band zero settle");
        run_cal(5,  3, 100, 0, 0, "bottom band long settle R3");
        t_hold();
        run_cal(30, 3, 20, 600, 60, "restart ignored R8 R9");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule